// File: doc/BRIEF.md
# PCIe Controller Client Glue Registers

This block is a small register file on a 32-bit APB-style slave that sits next to a PCIe controller core. Software uses it to pick endpoint or root-complex operation, to enable link training, to drive the reference-clock request handshake, and to read the training state and link status that the core reports. It also turns core events into two level interrupts. One interrupt carries the four legacy INTx sources. The other carries a data-link-layer up/down change and a hot-reset or link-down reset request.

Every control register uses a per-bit write enable. Bits [31:16] of the write data say which of bits [15:0] a write changes, so software can update one field without first reading the register. In endpoint operation a delay hook can hold the link-training enable low after a reset request. The hold stays in place until software writes a done strobe. This gives firmware time to reconfigure the core before the link trains again.

Top module: `pcie_client_regs`

## Requirements
- R1: In the general control, power control, hot-reset control and both mask registers, a write changes bit i of [15:0] only where bit i+16 of the written data is 1. Only bits the register implements are stored. Reads return 0 in bits [31:16] and in unimplemented bits.
- R2: General control is at offset 0x000. Bits [7:4] form the mode field, driven on mode_o, with 0x0 meaning endpoint and 0x4 meaning root complex. Bit 3 drives rst_grant_o. Bit 2 drives ltssm_en_o whenever no hold is active.
- R3: Offset 0x008 reads intx_in as registered one clock earlier, INTA..INTD in bits [3:0]. The legacy mask at offset 0x01C implements bits [7:0], and a 1 masks a source. legacy_irq_o is the OR of the unmasked pending sources. It is a level and follows intx_in one clock later.
- R4: Miscellaneous status is at offset 0x010. Bit 1 latches when the level of link_up_in changes. link_up_in passes through a two-flop synchronizer, so a change made before rising edge k latches at edge k+2. Bit 2 latches on any edge where rst_req_in is 1. Writing a 1 to a bit clears it. An event and a clear on the same edge leave the bit set.
- R5: The miscellaneous mask is at offset 0x024. A 0 in bit 1 or bit 2 lets the matching status bit onto sys_irq_o, which is the OR of the unmasked status bits.
- R6: Power control is at offset 0x02C. Bit 0 drives clkreq_ready_o and bits [13:12] drive clkreq_pd_o.
- R7: Hot-reset control is at offset 0x180 and stores bit 4 (enhanced enable control) and bit 1 (delay enable). While the delay is enabled, rst_req_in sets a hold from the next clock, and the hold forces ltssm_en_o low. A write to 0x180 with bits 3 and 19 both 1 releases the hold. Bit 3 always reads 0. A request on the same edge as the release keeps the hold. Without the delay enabled, a request sets no hold.
- R8: Offset 0x300 reads ltssm_state_in in bits [5:0] and link_status_in in bits [17:16], with all other bits 0. link_up_o is 1 exactly when link_status_in is 2'b11.
- R9: Unmapped offsets read as 0, and writes to them change no register.
- R10: After reset every register reads 0 except the legacy mask, which reads 0x000000FF, and the miscellaneous mask, which reads 0x0000FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data, upper half is the write enable |
| prdata | output | 32 | Read data |
| intx_in | input | 4 | Legacy interrupt levels from the core |
| link_up_in | input | 1 | Data-link-layer up, asynchronous |
| rst_req_in | input | 1 | Hot or link-down reset request, synchronous |
| ltssm_state_in | input | 6 | Training state from the core |
| link_status_in | input | 2 | Link status from the core |
| ltssm_en_o | output | 1 | Link-training enable to the core |
| mode_o | output | 4 | Device mode field |
| rst_grant_o | output | 1 | Link-down reset grant |
| clkreq_ready_o | output | 1 | Clock request ready |
| clkreq_pd_o | output | 2 | Clock request pull-down force |
| link_up_o | output | 1 | Link up decoded from link status |
| legacy_irq_o | output | 1 | Legacy interrupt level |
| sys_irq_o | output | 1 | Miscellaneous event interrupt level |

## Verification
Two collisions can happen on a single edge, and the bench provokes both. First, a write-one-to-clear of the reset-request status bit can land on the edge where rst_req_in is high. Second, the done strobe that releases the training hold can land on the edge where a new request arrives. The bench raises rst_req_in during the access phase of that very write. It then judges the result at the ports: the status bit must read back as 1, and ltssm_en_o must stay low, which shows the event won in both cases.

// File: rtl/pcie_client_pkg.sv
package pcie_client_pkg;
  localparam int HALF_W   = 16;
  localparam int REG_W    = 2 * HALF_W;
  localparam int NUM_INTX = 4;
  localparam int OFS_W    = 12;

  localparam logic [OFS_W-1:0] OFS_GEN   = 12'h000;
  localparam logic [OFS_W-1:0] OFS_LSTAT = 12'h008;
  localparam logic [OFS_W-1:0] OFS_MSTAT = 12'h010;
  localparam logic [OFS_W-1:0] OFS_LMASK = 12'h01C;
  localparam logic [OFS_W-1:0] OFS_MMASK = 12'h024;
  localparam logic [OFS_W-1:0] OFS_PWR   = 12'h02C;
  localparam logic [OFS_W-1:0] OFS_HRST  = 12'h180;
  localparam logic [OFS_W-1:0] OFS_LTSSM = 12'h300;

  localparam logic [HALF_W-1:0] IMPL_GEN   = 16'h00FC;
  localparam logic [HALF_W-1:0] IMPL_PWR   = 16'h3001;
  localparam logic [HALF_W-1:0] IMPL_HRST  = 16'h0012;
  localparam logic [HALF_W-1:0] IMPL_LMASK = 16'h00FF;
  localparam logic [HALF_W-1:0] IMPL_MMASK = 16'hFFFF;

  localparam int BIT_LTSSM_EN = 2;
  localparam int BIT_GRANT    = 3;
  localparam int BIT_DLY_EN   = 1;
  localparam int BIT_DONE     = 3;
  localparam int BIT_EV_LINK  = 1;
  localparam int BIT_EV_RST   = 2;
endpackage

// File: rtl/pcie_wm16_reg.sv
module pcie_wm16_reg #(
  parameter int                HALF_W  = 16,
  parameter logic [HALF_W-1:0] IMPL    = '1,
  parameter logic [HALF_W-1:0] RST_VAL = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2*HALF_W-1:0] wdata,
  output logic [HALF_W-1:0]   q
);
  logic [HALF_W-1:0] bit_we;
  logic [HALF_W-1:0] q_nxt;

  always_comb begin
    bit_we = wdata[2*HALF_W-1:HALF_W] & IMPL & {HALF_W{wr_en}};
    q_nxt  = (q & ~bit_we) | (wdata[HALF_W-1:0] & bit_we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL & IMPL;
    end else if (|bit_we) begin
      q <= q_nxt;
    end
  end

  // R1: a write with an all-zero enable half leaves the register alone
  p_unenabled_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[2*HALF_W-1:HALF_W] == '0) |=> (q == $past(q)));
endmodule

// File: rtl/pcie_sync.sv
module pcie_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= 1'b0;
        else        st[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= 1'b0;
        else        st[s] <= st[s-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pcie_misc_events.sv
module pcie_misc_events #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_up_async,
  input  logic       rst_req,
  input  logic       w1c_en,
  input  logic [1:0] w1c_bits,
  input  logic       dly_en,
  input  logic       done_wr,
  output logic [1:0] ev_stat,
  output logic       hold
);
  logic       lu_sync;
  logic       lu_prev;
  logic       lu_chg;
  logic [1:0] ev_set;
  logic [1:0] ev_clr;
  logic [1:0] stat_nxt;
  logic       hold_nxt;

  pcie_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (link_up_async),
    .q     (lu_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lu_prev <= 1'b0;
    else        lu_prev <= lu_sync;
  end

  always_comb begin
    lu_chg   = lu_sync ^ lu_prev;
    ev_set   = {rst_req, lu_chg};
    ev_clr   = w1c_bits & {2{w1c_en}};
    stat_nxt = (ev_stat & ~ev_clr) | ev_set;
    hold_nxt = hold;
    if (dly_en && rst_req) hold_nxt = 1'b1;
    else if (done_wr)      hold_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_stat <= 2'b00;
    end else if ((|ev_set) || (|ev_clr)) begin
      ev_stat <= stat_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0;
    end else if ((dly_en && rst_req) || done_wr) begin
      hold <= hold_nxt;
    end
  end

  // R4: a reset request always leaves its status bit set, even under a clear
  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> ev_stat[1]);

  // R7: a request with the delay enabled always leads to a hold
  p_hold_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_en && rst_req) |=> hold);

  // R7: the hold only ends through a done write
  p_hold_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !done_wr) |=> hold);
endmodule

// File: rtl/pcie_client_regs.sv
module pcie_client_regs
  import pcie_client_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [REG_W-1:0]  pwdata,
  output logic [REG_W-1:0]  prdata,
  input  logic [NUM_INTX-1:0] intx_in,
  input  logic              link_up_in,
  input  logic              rst_req_in,
  input  logic [5:0]        ltssm_state_in,
  input  logic [1:0]        link_status_in,
  output logic              ltssm_en_o,
  output logic [3:0]        mode_o,
  output logic              rst_grant_o,
  output logic              clkreq_ready_o,
  output logic [1:0]        clkreq_pd_o,
  output logic              link_up_o,
  output logic              legacy_irq_o,
  output logic              sys_irq_o
);
  logic                wr;
  logic                wr_gen, wr_pwr, wr_hrst, wr_lmask, wr_mmask, wr_mstat;
  logic                done_wr;
  logic [HALF_W-1:0]   gen_q, pwr_q, hrst_q, lmask_q, mmask_q;
  logic [NUM_INTX-1:0] intx_q;
  logic [1:0]          ev_stat;
  logic                hold;

  always_comb begin
    wr       = psel && penable && pwrite;
    wr_gen   = wr && (paddr == ADDR_W'(OFS_GEN));
    wr_pwr   = wr && (paddr == ADDR_W'(OFS_PWR));
    wr_hrst  = wr && (paddr == ADDR_W'(OFS_HRST));
    wr_lmask = wr && (paddr == ADDR_W'(OFS_LMASK));
    wr_mmask = wr && (paddr == ADDR_W'(OFS_MMASK));
    wr_mstat = wr && (paddr == ADDR_W'(OFS_MSTAT));
    done_wr  = wr_hrst && pwdata[BIT_DONE] && pwdata[BIT_DONE+HALF_W];
  end

  pcie_wm16_reg #(.HALF_W(HALF_W), .IMPL(IMPL_GEN), .RST_VAL(16'h0000)) u_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_gen), .wdata(pwdata), .q(gen_q));
  pcie_wm16_reg #(.HALF_W(HALF_W), .IMPL(IMPL_PWR), .RST_VAL(16'h0000)) u_pwr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_pwr), .wdata(pwdata), .q(pwr_q));
  pcie_wm16_reg #(.HALF_W(HALF_W), .IMPL(IMPL_HRST), .RST_VAL(16'h0000)) u_hrst (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_hrst), .wdata(pwdata), .q(hrst_q));
  pcie_wm16_reg #(.HALF_W(HALF_W), .IMPL(IMPL_LMASK), .RST_VAL(16'hFFFF)) u_lmask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_lmask), .wdata(pwdata), .q(lmask_q));
  pcie_wm16_reg #(.HALF_W(HALF_W), .IMPL(IMPL_MMASK), .RST_VAL(16'hFFFF)) u_mmask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mmask), .wdata(pwdata), .q(mmask_q));

  pcie_misc_events #(.SYNC_STAGES(SYNC_STAGES)) u_ev (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_up_async (link_up_in),
    .rst_req       (rst_req_in),
    .w1c_en        (wr_mstat),
    .w1c_bits      ({pwdata[BIT_EV_RST], pwdata[BIT_EV_LINK]}),
    .dly_en        (hrst_q[BIT_DLY_EN]),
    .done_wr       (done_wr),
    .ev_stat       (ev_stat),
    .hold          (hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intx_q <= '0;
    else        intx_q <= intx_in;
  end

  always_comb begin
    ltssm_en_o     = gen_q[BIT_LTSSM_EN] && !hold;
    mode_o         = gen_q[7:4];
    rst_grant_o    = gen_q[BIT_GRANT];
    clkreq_ready_o = pwr_q[0];
    clkreq_pd_o    = pwr_q[13:12];
    link_up_o      = (link_status_in == 2'b11);
    legacy_irq_o   = |(intx_q & ~lmask_q[NUM_INTX-1:0]);
    sys_irq_o      = |(ev_stat & ~{mmask_q[BIT_EV_RST], mmask_q[BIT_EV_LINK]});
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      ADDR_W'(OFS_GEN):   prdata[HALF_W-1:0] = gen_q;
      ADDR_W'(OFS_LSTAT): prdata[NUM_INTX-1:0] = intx_q;
      ADDR_W'(OFS_MSTAT): prdata[BIT_EV_RST:BIT_EV_LINK] = ev_stat;
      ADDR_W'(OFS_LMASK): prdata[HALF_W-1:0] = lmask_q;
      ADDR_W'(OFS_MMASK): prdata[HALF_W-1:0] = mmask_q;
      ADDR_W'(OFS_PWR):   prdata[HALF_W-1:0] = pwr_q;
      ADDR_W'(OFS_HRST):  prdata[HALF_W-1:0] = hrst_q;
      ADDR_W'(OFS_LTSSM): prdata = {14'b0, link_status_in, 10'b0, ltssm_state_in};
      default:            prdata = '0;
    endcase
  end

  // R7: while held, training stays disabled
  p_held_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !ltssm_en_o);

  // R3: fully masked legacy sources never interrupt
  p_legacy_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&lmask_q[NUM_INTX-1:0]) |-> !legacy_irq_o);

  // R5: with both event bits masked the system interrupt stays low
  p_sys_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mmask_q[BIT_EV_LINK] && mmask_q[BIT_EV_RST]) |-> !sys_irq_o);

  // R4: status bits only appear after an event
  p_stat_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_stat[1]) |-> $past(rst_req_in));
endmodule

// File: tb/tb_pcie_client_regs.sv
`timescale 1ns/1ps
module tb_pcie_client_regs;
  logic        clk;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic [3:0]  intx_in;
  logic        link_up_in, rst_req_in;
  logic [5:0]  ltssm_state_in;
  logic [1:0]  link_status_in;
  logic        ltssm_en_o, rst_grant_o, clkreq_ready_o, link_up_o;
  logic        legacy_irq_o, sys_irq_o;
  logic [3:0]  mode_o;
  logic [1:0]  clkreq_pd_o;

  int n_chk = 0;
  int n_bad = 0;

  pcie_client_regs dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .intx_in(intx_in),
    .link_up_in(link_up_in), .rst_req_in(rst_req_in),
    .ltssm_state_in(ltssm_state_in), .link_status_in(link_status_in),
    .ltssm_en_o(ltssm_en_o), .mode_o(mode_o), .rst_grant_o(rst_grant_o),
    .clkreq_ready_o(clkreq_ready_o), .clkreq_pd_o(clkreq_pd_o),
    .link_up_o(link_up_o), .legacy_irq_o(legacy_irq_o), .sys_irq_o(sys_irq_o));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, input logic req);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1; rst_req_in = req;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; rst_req_in = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); rst_req_in = 1'b1;
    @(negedge clk); rst_req_in = 1'b0;
  endtask

  function automatic logic [15:0] wm(input logic [15:0] cur, input logic [31:0] d,
                                     input logic [15:0] impl);
    logic [15:0] we;
    we = d[31:16] & impl;
    return (cur & ~we) | (d[15:0] & we);
  endfunction

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] gen_m, pwr_m;
    logic [31:0] x;
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    intx_in = 0; link_up_in = 0; rst_req_in = 0;
    ltssm_state_in = 0; link_status_in = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset values
    apb_rd(12'h000, rd); chk("R10 gen", rd, 32'h0);
    apb_rd(12'h008, rd); chk("R10 lstat", rd, 32'h0);
    apb_rd(12'h010, rd); chk("R10 mstat", rd, 32'h0);
    apb_rd(12'h01C, rd); chk("R10 lmask", rd, 32'h000000FF);
    apb_rd(12'h024, rd); chk("R10 mmask", rd, 32'h0000FFFF);
    apb_rd(12'h02C, rd); chk("R10 pwr", rd, 32'h0);
    apb_rd(12'h180, rd); chk("R10 hrst", rd, 32'h0);
    chk("R10 outputs", {ltssm_en_o, rst_grant_o, clkreq_ready_o, legacy_irq_o, sys_irq_o}, 0);

    // R1 R2 general control sweep with mixed enables
    gen_m = 0;
    for (int k = 0; k < 64; k++) begin
      x = k * 32'h9E3779B9 ^ 32'h5A5A0F0F;
      apb_wr(12'h000, x, 1'b0);
      gen_m = wm(gen_m, x, 16'h00FC);
      apb_rd(12'h000, rd);
      chk("R1 gen readback", rd, {16'h0, gen_m});
      chk("R2 mode_o", mode_o, gen_m[7:4]);
      chk("R2 grant/ltssm", {rst_grant_o, ltssm_en_o}, {gen_m[3], gen_m[2]});
    end
    apb_wr(12'h000, 32'h00F00040, 1'b0);
    gen_m = wm(gen_m, 32'h00F00040, 16'h00FC);
    chk("R2 root complex mode", mode_o, 4'h4);
    apb_wr(12'h000, 32'h00F00000, 1'b0);
    gen_m = wm(gen_m, 32'h00F00000, 16'h00FC);
    chk("R2 endpoint mode", mode_o, 4'h0);

    // R6 R1 power control sweep
    pwr_m = 0;
    for (int k = 0; k < 24; k++) begin
      x = (k + 3) * 32'h2545F491;
      apb_wr(12'h02C, x, 1'b0);
      pwr_m = wm(pwr_m, x, 16'h3001);
      apb_rd(12'h02C, rd);
      chk("R6 pwr readback", rd, {16'h0, pwr_m});
      chk("R6 clkreq outputs", {clkreq_pd_o, clkreq_ready_o}, {pwr_m[13:12], pwr_m[0]});
    end

    // R3 legacy mask x source sweep
    for (int m = 0; m < 256; m++) begin
      apb_wr(12'h01C, {16'h00FF, 8'h00, 8'(m)}, 1'b0);
      for (int s = 0; s < 16; s++) begin
        @(negedge clk); intx_in = 4'(s);
        @(negedge clk);
        chk("R3 legacy_irq_o", legacy_irq_o, |(4'(s) & ~4'(m)));
      end
      apb_rd(12'h008, rd);
      chk("R3 lstat", rd, {28'h0, intx_in});
    end
    apb_rd(12'h01C, rd); chk("R3 lmask readback", rd, 32'h000000FF);
    intx_in = 0;

    // R4 link change latency via sys_irq_o
    apb_wr(12'h024, 32'h00060004, 1'b0); // unmask bit1, keep bit2 masked
    @(negedge clk); link_up_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 link change not yet", sys_irq_o, 1'b0);
    @(negedge clk);
    chk("R4 link change latched", sys_irq_o, 1'b1);
    apb_rd(12'h010, rd); chk("R4 mstat link", rd, 32'h2);
    apb_wr(12'h010, 32'h2, 1'b0);
    apb_rd(12'h010, rd); chk("R4 w1c clears", rd, 32'h0);
    chk("R5 irq drops", sys_irq_o, 1'b0);
    // link down also counts as a change
    @(negedge clk); link_up_in = 1'b0;
    repeat (4) @(negedge clk);
    apb_rd(12'h010, rd); chk("R4 link down change", rd, 32'h2);

    // R4 reset request and collision with W1C
    pulse_req();
    apb_rd(12'h010, rd); chk("R4 rst req latched", rd, 32'h6);
    apb_wr(12'h010, 32'h4, 1'b1);
    apb_rd(12'h010, rd); chk("R4 event wins over clear", rd, 32'h6);
    apb_wr(12'h010, 32'h4, 1'b0);
    apb_rd(12'h010, rd); chk("R4 clear bit2 only", rd, 32'h2);
    pulse_req();

    // R5 mask sweep with both events pending, then one
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 4; c++) begin
        apb_wr(12'h024, {16'h0006, 13'h0, 2'(c), 1'b0}, 1'b0);
        chk("R5 sys_irq_o", sys_irq_o, (p == 0) ? (c != 3) : !c[1]);
      end
      apb_wr(12'h010, 32'h2, 1'b0);
    end
    apb_wr(12'h010, 32'h6, 1'b0);
    apb_wr(12'h024, 32'h00060000, 1'b0);
    chk("R5 nothing pending", sys_irq_o, 1'b0);
    apb_rd(12'h024, rd); chk("R5 mmask readback", rd, 32'h0000FFF9);

    // R7 hold after reset request
    apb_wr(12'h000, 32'h00040004, 1'b0);
    gen_m = wm(gen_m, 32'h00040004, 16'h00FC);
    apb_wr(12'h180, 32'h00120012, 1'b0);
    chk("R7 enabled before request", ltssm_en_o, 1'b1);
    pulse_req();
    chk("R7 held after request", ltssm_en_o, 1'b0);
    repeat (5) @(negedge clk);
    chk("R7 still held", ltssm_en_o, 1'b0);
    apb_wr(12'h180, 32'h00000008, 1'b0);
    chk("R7 done without enable ignored", ltssm_en_o, 1'b0);
    apb_wr(12'h180, 32'h00080008, 1'b1);
    chk("R7 request beats done", ltssm_en_o, 1'b0);
    apb_wr(12'h180, 32'h00080008, 1'b0);
    chk("R7 released by done", ltssm_en_o, 1'b1);
    apb_rd(12'h180, rd); chk("R7 done reads 0", rd, 32'h00000012);
    apb_wr(12'h180, 32'h00020000, 1'b0);
    pulse_req();
    chk("R7 no hold without delay", ltssm_en_o, 1'b1);
    apb_rd(12'h180, rd); chk("R7 hrst readback", rd, 32'h00000010);

    // R8 ltssm status
    for (int st = 0; st < 4; st++) begin
      @(negedge clk);
      link_status_in = 2'(st);
      ltssm_state_in = 6'(st * 13 + 5);
      apb_rd(12'h300, rd);
      chk("R8 ltssm read", rd, {14'h0, 2'(st), 10'h0, 6'(st * 13 + 5)});
      chk("R8 link_up_o", link_up_o, (st == 3));
    end

    // R9 unmapped offsets
    for (int u = 0; u < 6; u++) begin
      logic [11:0] ua;
      ua = (u == 0) ? 12'h004 : (u == 1) ? 12'h014 : (u == 2) ? 12'h020 :
           (u == 3) ? 12'h100 : (u == 4) ? 12'h184 : 12'h304;
      apb_wr(ua, 32'hFFFFFFFF, 1'b0);
      apb_rd(ua, rd);
      chk("R9 unmapped reads 0", rd, 32'h0);
    end
    apb_rd(12'h000, rd); chk("R9 gen unchanged", rd, {16'h0, gen_m});
    apb_rd(12'h02C, rd); chk("R9 pwr unchanged", rd, {16'h0, pwr_m});
    apb_rd(12'h024, rd); chk("R9 mmask unchanged", rd, 32'h0000FFF9);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule